// File: doc/BRIEF.md
# Boot Region Write Lockout Guard

This block keeps the write-protection state for the boot region of a 512K-byte flash array. Either end of the address space can be protected, and the protected span at an end is 16K bytes or 64K bytes. A command decoder sends the block one decoded request per lockout command. The request carries the chosen size and the chosen end. The protection is one-way: a request can add or widen a lock, but nothing removes it. The power-on value of each end is a parameter, which stands in for the non-volatile cell.

Before the array controller runs a program or erase, it asks the block whether the operation must be refused. A byte program is tested against its single address. A page or sector erase is tested against its whole aligned span. A chip erase is refused whenever any lock exists. In identification mode the read path can fetch a status byte for either end from two fixed addresses.

After each accepted lockout request the block reports busy for a parameterized number of cycles. Any lockout request that arrives during that time is dropped.

Top module: `lk_boot_guard`

## Requirements
- R1: While `rst` is high and after it falls, `busy`, `chk_done` and `chk_refuse` are 0. Each end holds its parameter reset level, which is unlocked by default.
- R2: A lockout request accepted on `set_valid` locks 64K bytes when `set_big`=1 and 16K bytes when `set_big`=0. It locks the top end when `set_top`=1 and the bottom end when `set_top`=0.
- R3: A check with `chk_op`=00 (byte program) is refused exactly when `chk_addr` lies in a locked span. The top spans are 7C000h–7FFFFh (16K) and 70000h–7FFFFh (64K). The bottom spans are 00000h–03FFFh (16K) and 00000h–0FFFFh (64K). `chk_done` and `chk_refuse` are valid one cycle after `chk_valid`.
- R4: A check with `chk_op`=01 (page erase, 4K span with `chk_addr[11:0]` ignored) or `chk_op`=10 (sector erase, 64K span with `chk_addr[15:0]` ignored) is refused when any byte of the span overlaps a locked span.
- R5: A check with `chk_op`=11 (chip erase) is refused exactly when at least one end is locked.
- R6: Locks are sticky. A 64K request widens a 16K lock. A 16K request leaves an existing 64K lock unchanged. No input clears a lock.
- R7: Once a request is accepted, `busy` is 1 for exactly BUSY_CYCLES cycles. A `set_valid` during `busy` changes no lock and does not restart the count.
- R8: One cycle after `id_addr` is presented, `id_status` shows a status code in bits [1:0]. Address 00002h gives the bottom end's code and 7FFF2h gives the top end's code. The codes are 10 for a 16K lock, 11 for a 64K lock and 00 for no lock. Bits [7:2] are 0, and any other address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | Decoded lockout request strobe |
| set_big | input | 1 | Request size: 1 = 64K, 0 = 16K |
| set_top | input | 1 | Request end: 1 = top, 0 = bottom |
| busy | output | 1 | Lockout request in progress |
| chk_valid | input | 1 | Protection query strobe |
| chk_op | input | 2 | Operation kind: 00 program, 01 page, 10 sector, 11 chip |
| chk_addr | input | 19 | Target address of the operation |
| chk_done | output | 1 | Query answer valid |
| chk_refuse | output | 1 | Operation touches a locked span |
| id_addr | input | 19 | Identification-mode read address |
| id_status | output | 8 | Status byte for that address |

## Verification
A query answer and an identification byte are both registered once, so each is due one clock edge after its input is applied. The bench drives every input on a falling edge and reads the result on the next falling edge. A lock changes on the edge that accepts the request, and `busy` rises on that same edge. The bench therefore counts busy cycles from the falling edge that follows the strobe and expects exactly BUSY_CYCLES of them. Refusals are compared against bench-computed span overlaps, first for directed addresses at each span boundary and then for seeded random addresses that cluster near both ends.

// File: rtl/lk_pkg.sv
package lk_pkg;
    localparam int ADDR_W = 19;
    localparam int STAT_W = 8;

    typedef enum logic [1:0] {
        LVL_NONE = 2'b00,
        LVL_16K  = 2'b10,
        LVL_64K  = 2'b11
    } lk_lvl_t;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_PAGE = 2'b01,
        OP_SECT = 2'b10,
        OP_CHIP = 2'b11
    } lk_op_t;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } lk_span_t;

    localparam logic [ADDR_W-1:0] ID_ADDR_BOT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ID_ADDR_TOP = {ADDR_W{1'b1}} ^ ADDR_W'(13);

    function automatic lk_lvl_t lvl_widen(lk_lvl_t cur, lk_lvl_t req);
        return (req > cur) ? req : cur;
    endfunction

    function automatic logic span_overlap(lk_span_t a, lk_span_t b);
        return (a.lo <= b.hi) && (b.lo <= a.hi);
    endfunction
endpackage

// File: rtl/lk_store.sv
module lk_store
    import lk_pkg::*;
#(
    parameter lk_lvl_t RESET_TOP   = LVL_NONE,
    parameter lk_lvl_t RESET_BOT   = LVL_NONE,
    parameter int      BUSY_CYCLES = 100
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    set_valid,
    input  logic    set_big,
    input  logic    set_top,
    output lk_lvl_t top_lvl,
    output lk_lvl_t bot_lvl,
    output logic    busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    lk_lvl_t          req_lvl;
    logic             take;

    assign req_lvl = set_big ? LVL_64K : LVL_16K;
    assign take    = set_valid && (cnt == '0);
    assign busy    = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            top_lvl <= RESET_TOP;
            bot_lvl <= RESET_BOT;
            cnt     <= '0;
        end else begin
            if (take) begin
                if (set_top) top_lvl <= lvl_widen(top_lvl, req_lvl);
                else         bot_lvl <= lvl_widen(bot_lvl, req_lvl);
                cnt <= CNT_W'(BUSY_CYCLES);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/lk_guard.sv
module lk_guard
    import lk_pkg::*;
#(
    parameter int SMALL_LOG = 14,
    parameter int BIG_LOG   = 16,
    parameter int PAGE_LOG  = 12,
    parameter int SECT_LOG  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_valid,
    input  lk_op_t            chk_op,
    input  logic [ADDR_W-1:0] chk_addr,
    input  lk_lvl_t           top_lvl,
    input  lk_lvl_t           bot_lvl,
    output logic              chk_done,
    output logic              chk_refuse
);
    localparam logic [ADDR_W-1:0] ONES    = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] SMALL_M = ONES >> (ADDR_W - SMALL_LOG);
    localparam logic [ADDR_W-1:0] BIG_M   = ONES >> (ADDR_W - BIG_LOG);
    localparam logic [ADDR_W-1:0] PAGE_M  = ONES >> (ADDR_W - PAGE_LOG);
    localparam logic [ADDR_W-1:0] SECT_M  = ONES >> (ADDR_W - SECT_LOG);

    logic [ADDR_W-1:0] op_mask;
    lk_span_t          op_span;
    logic [1:0]        end_hit;

    always_comb begin
        unique case (chk_op)
            OP_PROG: op_mask = '0;
            OP_PAGE: op_mask = PAGE_M;
            OP_SECT: op_mask = SECT_M;
            default: op_mask = ONES;
        endcase
        op_span.lo = chk_addr & ~op_mask;
        op_span.hi = chk_addr | op_mask;
    end

    // index 0: bottom end, index 1: top end
    for (genvar e = 0; e < 2; e++) begin : g_end
        lk_lvl_t           lv;
        logic [ADDR_W-1:0] size_m;
        lk_span_t          region;

        assign lv     = (e == 1) ? top_lvl : bot_lvl;
        assign size_m = (lv == LVL_64K) ? BIG_M : SMALL_M;

        if (e == 1) begin : g_top
            assign region.lo = ~size_m;
            assign region.hi = ONES;
        end else begin : g_bot
            assign region.lo = '0;
            assign region.hi = size_m;
        end

        assign end_hit[e] = (lv != LVL_NONE) && span_overlap(op_span, region);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_done   <= 1'b0;
            chk_refuse <= 1'b0;
        end else begin
            chk_done   <= chk_valid;
            chk_refuse <= chk_valid && (end_hit != 2'b00);
        end
    end
endmodule

// File: rtl/lk_idread.sv
module lk_idread
    import lk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] id_addr,
    input  lk_lvl_t           top_lvl,
    input  lk_lvl_t           bot_lvl,
    output logic [STAT_W-1:0] id_status
);
    lk_lvl_t sel;

    always_comb begin
        if (id_addr == ID_ADDR_BOT)      sel = bot_lvl;
        else if (id_addr == ID_ADDR_TOP) sel = top_lvl;
        else                             sel = LVL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) id_status <= '0;
        else     id_status <= {{(STAT_W-2){1'b0}}, sel};
    end
endmodule

// File: rtl/lk_boot_guard.sv
module lk_boot_guard
    import lk_pkg::*;
#(
    parameter lk_lvl_t RESET_TOP   = LVL_NONE,
    parameter lk_lvl_t RESET_BOT   = LVL_NONE,
    parameter int      BUSY_CYCLES = 100,
    parameter int      SMALL_LOG   = 14,
    parameter int      BIG_LOG     = 16,
    parameter int      PAGE_LOG    = 12,
    parameter int      SECT_LOG    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        set_valid,
    input  logic        set_big,
    input  logic        set_top,
    output logic        busy,
    input  logic        chk_valid,
    input  logic [1:0]  chk_op,
    input  logic [18:0] chk_addr,
    output logic        chk_done,
    output logic        chk_refuse,
    input  logic [18:0] id_addr,
    output logic [7:0]  id_status
);
    lk_lvl_t top_lvl;
    lk_lvl_t bot_lvl;
    lk_op_t  op_q;

    assign op_q = lk_op_t'(chk_op);

    lk_store #(
        .RESET_TOP  (RESET_TOP),
        .RESET_BOT  (RESET_BOT),
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .set_valid(set_valid),
        .set_big  (set_big),
        .set_top  (set_top),
        .top_lvl  (top_lvl),
        .bot_lvl  (bot_lvl),
        .busy     (busy)
    );

    lk_guard #(
        .SMALL_LOG(SMALL_LOG),
        .BIG_LOG  (BIG_LOG),
        .PAGE_LOG (PAGE_LOG),
        .SECT_LOG (SECT_LOG)
    ) u_guard (
        .clk       (clk),
        .rst       (rst),
        .chk_valid (chk_valid),
        .chk_op    (op_q),
        .chk_addr  (chk_addr),
        .top_lvl   (top_lvl),
        .bot_lvl   (bot_lvl),
        .chk_done  (chk_done),
        .chk_refuse(chk_refuse)
    );

    lk_idread u_id (
        .clk      (clk),
        .rst      (rst),
        .id_addr  (id_addr),
        .top_lvl  (top_lvl),
        .bot_lvl  (bot_lvl),
        .id_status(id_status)
    );
endmodule

// File: rtl/lk_boot_guard_chk.sv
module lk_boot_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       set_valid,
    input logic       busy,
    input logic       chk_valid,
    input logic [1:0] chk_op,
    input logic       chk_done,
    input logic       chk_refuse,
    input logic [1:0] top_lvl,
    input logic [1:0] bot_lvl
);
    assert_top_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (top_lvl >= $past(top_lvl)));

    assert_bot_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bot_lvl >= $past(bot_lvl)));

    assert_busy_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(set_valid));

    assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && set_valid) |=> ($stable(top_lvl) && $stable(bot_lvl)));

    assert_answer_due_R3: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> chk_done);

    assert_answer_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> (!chk_done && !chk_refuse));

    assert_chip_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_op == 2'b11 && (top_lvl != 2'b00 || bot_lvl != 2'b00))
        |=> chk_refuse);

    assert_chip_free_R5: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_op == 2'b11 && top_lvl == 2'b00 && bot_lvl == 2'b00)
        |=> !chk_refuse);
endmodule

bind lk_boot_guard lk_boot_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .set_valid (set_valid),
    .busy      (busy),
    .chk_valid (chk_valid),
    .chk_op    (chk_op),
    .chk_done  (chk_done),
    .chk_refuse(chk_refuse),
    .top_lvl   (top_lvl),
    .bot_lvl   (bot_lvl)
);

// File: tb/sim_lk_boot_guard.sv
module sim_lk_boot_guard;
    localparam int BUSY_N = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_valid = 1'b0, set_big = 1'b0, set_top = 1'b0;
    logic        busy;
    logic        chk_valid = 1'b0;
    logic [1:0]  chk_op = 2'b00;
    logic [18:0] chk_addr = '0;
    logic        chk_done, chk_refuse;
    logic [18:0] id_addr = '0;
    logic [7:0]  id_status;

    int n_chk = 0, n_fail = 0;
    logic finished = 1'b0;
    logic [1:0] m_top = 2'b00, m_bot = 2'b00;

    always #5 clk = ~clk;

    lk_boot_guard #(.BUSY_CYCLES(BUSY_N)) u0 (
        .clk(clk), .rst(rst), .set_valid(set_valid), .set_big(set_big),
        .set_top(set_top), .busy(busy), .chk_valid(chk_valid), .chk_op(chk_op),
        .chk_addr(chk_addr), .chk_done(chk_done), .chk_refuse(chk_refuse),
        .id_addr(id_addr), .id_status(id_status)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int span_size(logic [1:0] lv);
        return (lv == 2'b11) ? 32'h10000 : 32'h4000;
    endfunction

    function automatic logic exp_refuse(logic [1:0] op, logic [18:0] a);
        int lo, hi, sz;
        logic r;
        case (op)
            2'b00: begin lo = a; hi = a; end
            2'b01: begin lo = a & ~32'hFFF;  hi = lo + 32'hFFF; end
            2'b10: begin lo = a & ~32'hFFFF; hi = lo + 32'hFFFF; end
            default: begin lo = 0; hi = 32'h7FFFF; end
        endcase
        r = 1'b0;
        if (m_bot != 2'b00) begin
            sz = span_size(m_bot);
            if (lo <= sz - 1) r = 1'b1;
        end
        if (m_top != 2'b00) begin
            sz = span_size(m_top);
            if (hi >= 32'h80000 - sz) r = 1'b1;
        end
        return r;
    endfunction

    task automatic query(string req, logic [1:0] op, logic [18:0] a);
        @(negedge clk);
        chk_valid = 1'b1; chk_op = op; chk_addr = a;
        @(negedge clk);
        chk_valid = 1'b0;
        check({req, " done"}, {31'd0, chk_done}, 32'd1);
        check({req, " refuse"}, {31'd0, chk_refuse}, {31'd0, exp_refuse(op, a)});
    endtask

    task automatic id_read(string req, logic [18:0] a, logic [7:0] exp);
        @(negedge clk);
        id_addr = a;
        @(negedge clk);
        check(req, {24'd0, id_status}, {24'd0, exp});
    endtask

    // accepted request; optionally a second request in the middle of busy
    task automatic lock_req(logic big, logic top, logic extra, logic xbig, logic xtop);
        int n;
        logic [1:0] rl;
        while (busy) @(negedge clk);
        @(negedge clk);
        set_valid = 1'b1; set_big = big; set_top = top;
        @(negedge clk);
        set_valid = 1'b0;
        rl = big ? 2'b11 : 2'b10;
        if (top) m_top = (rl > m_top) ? rl : m_top;
        else     m_bot = (rl > m_bot) ? rl : m_bot;
        n = 0;
        while (busy && n < BUSY_N + 10) begin
            n++;
            if (extra && n == BUSY_N / 2) begin
                set_valid = 1'b1; set_big = xbig; set_top = xtop;
            end else begin
                set_valid = 1'b0;
            end
            @(negedge clk);
        end
        set_valid = 1'b0;
        check("R7 busy length", n, BUSY_N);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [18:0] a;
        r = $urandom(32'd24681);
        repeat (3) @(negedge clk);
        check("R1 busy in reset", {31'd0, busy}, 32'd0);
        check("R1 done in reset", {31'd0, chk_done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 refuse after reset", {31'd0, chk_refuse}, 32'd0);
        id_read("R1 R8 bottom unlocked", 19'h00002, 8'h00);
        id_read("R1 R8 top unlocked", 19'h7FFF2, 8'h00);
        query("R5 chip free", 2'b11, 19'h12345);

        for (int i = 0; i < 20; i++) begin
            r = $urandom;
            query("R3 R4 unlocked random", r[1:0], r[20:2]);
        end

        // top 16K
        lock_req(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        id_read("R2 R8 top 16K code", 19'h7FFF2, 8'h02);
        id_read("R8 bottom still clear", 19'h00002, 8'h00);
        query("R3 below top16", 2'b00, 19'h7BFFF);
        query("R3 top16 edge", 2'b00, 19'h7C000);
        query("R4 page below top16", 2'b01, 19'h7B800);
        query("R4 page in top16", 2'b01, 19'h7C123);
        query("R4 sector holding top16", 2'b10, 19'h70000);
        query("R4 sector free", 2'b10, 19'h6FFFF);
        query("R5 chip locked", 2'b11, 19'h00000);

        // bottom 64K; a top 64K request during busy must be dropped
        lock_req(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        id_read("R7 dropped request left top", 19'h7FFF2, 8'h02);
        id_read("R2 R8 bottom 64K code", 19'h00002, 8'h03);
        query("R3 bottom64 last", 2'b00, 19'h0FFFF);
        query("R3 above bottom64", 2'b00, 19'h10000);

        // shrink attempt and widen
        lock_req(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        id_read("R6 no shrink", 19'h00002, 8'h03);
        lock_req(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        id_read("R6 widen top", 19'h7FFF2, 8'h03);
        query("R3 below top64", 2'b00, 19'h6FFFF);
        query("R3 top64 edge", 2'b00, 19'h70000);
        query("R4 page top64", 2'b01, 19'h70FFF);
        id_read("R8 other address", 19'h7FFF3, 8'h00);
        id_read("R8 other address low", 19'h00000, 8'h00);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_top = 2'b00; m_bot = 2'b00;
        id_read("R1 reset reloads top", 19'h7FFF2, 8'h00);
        lock_req(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        id_read("R2 bottom 16K code", 19'h00002, 8'h02);
        query("R3 bottom16 last", 2'b00, 19'h03FFF);
        query("R3 above bottom16", 2'b00, 19'h04000);
        query("R4 sector holding bottom16", 2'b10, 19'h0ABCD);

        for (int i = 0; i < 200; i++) begin
            r = $urandom;
            a = r[20:2];
            if (r[22:21] == 2'b00) a = 19'h7FFFF - 19'(r[31:23] * 9'd211);
            if (r[22:21] == 2'b01) a = 19'(r[31:23] * 9'd211);
            query("R3 R4 R5 random", r[1:0], a);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule